// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is a synchronous master that pulls one conversion result out of a serial sigma-delta converter. The converter runs with its serial clock supplied from outside. The block watches the converter's active-low ready line. When that line falls, the block lowers an active-low select line. It then takes the most significant bit, which the converter places on its data line as soon as select falls. After that it toggles its own serial clock once for each remaining bit.

Bit timing is counted in system clock cycles. A bit period is `2*HALF_PERIOD` cycles, and the serial clock is high for the first half of each period after the first. The data line is sampled `SAMPLE_DELAY` cycles into every period, which is the mid-bit point with the default values. For a converter limited to 4 kHz, `HALF_PERIOD` is set to 125 µs of system clock. `SAMPLE_DELAY` must be at most `2*HALF_PERIOD-2`. The assembled word is presented with a one-cycle valid strobe, and select is then released so that the converter can stage its next result.

Top module: `sdadc_reader`

## Requirements
- R1: A synchronous reset (active-high `rst`) leaves `csN` high, `sclk` low, `wordValid` low and `word` zero.
- R2: `readyN` passes through two synchronising flops before edge detection. A high-to-low transition starts a read only when the block is idle. `csN` goes low on the third rising clock edge at which `readyN` has been sampled low.
- R3: For the first bit period (`2*HALF_PERIOD` cycles) after `csN` falls, `sclk` stays low. The most significant bit is taken in that period.
- R4: Exactly `WORD_BITS-1` serial clock pulses follow the first period, back to back. Each pulse is high for `HALF_PERIOD` cycles and then low for `HALF_PERIOD` cycles.
- R5: In every bit period, `sdata` is sampled `SAMPLE_DELAY` cycles after the period starts. A period starts when `csN` falls for the first bit and when `sclk` rises for each later bit.
- R6: Bits arrive MSB first. The first bit lands in `word[WORD_BITS-1]` and each later bit lands one position lower, down to `word[0]`.
- R7: `wordValid` is high for exactly one cycle, the cycle right after the last bit period ends, with `csN` still low. `word` changes only on the edge that raises `wordValid` and holds its value at all other times.
- R8: `csN` returns high in the cycle after `wordValid`, and `sclk` is high only while `csN` is low.
- R9: Once a read has started, it runs to completion. `readyN` rising, or falling again, during the read (including the valid cycle) changes nothing, and no second read is started by those edges.
- R10: Holding `readyN` low after a read does not start another one. A new read needs `readyN` to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| readyN | input | 1 | Converter result-ready line, active low, asynchronous |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock to the converter |
| word | output | WORD_BITS | Last assembled result |
| wordValid | output | 1 | One-cycle strobe marking a fresh `word` |

## Verification
The case that needs care is a new ready edge arriving while a read is still finishing. In particular, a falling edge can land in the valid cycle, which is the same cycle in which the block returns to idle. The bench sweeps the moment of a high-then-low pulse on `readyN` across a window of cycles around the end of a read. A behavioural model decides cycle by cycle whether each edge must be dropped or must start the next read. Select, serial clock, valid and word are then compared against that model every cycle, so both a start taken while busy and an edge lost just after idle show up as mismatches.

// File: rtl/sdadc_reader_pkg.sv
package sdadc_reader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_CLOCK = 2'd2,
    ST_DONE  = 2'd3
  } readState_t;

  typedef struct packed {
    logic shiftEn;  // take sdata into the shift register this cycle
    logic loadOut;  // move the shift register to the output word
  } ctrlStrobes_t;
endpackage

// File: rtl/sdadc_reader_sync.sv
module sdadc_reader_sync (
  input  logic clk,
  input  logic rst,
  input  logic readyN,
  output logic startPulse
);
  logic syncA, syncB, prevB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      prevB <= 1'b1;
    end else begin
      syncA <= readyN;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // high-to-low transition on the synchronised ready line
  assign startPulse = prevB & ~syncB;
endmodule

// File: rtl/sdadc_reader_ctrl.sv
module sdadc_reader_ctrl
  import sdadc_reader_pkg::*;
#(
  parameter int WORD_BITS    = 20,
  parameter int HALF_PERIOD  = 4,
  parameter int SAMPLE_DELAY = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  output ctrlStrobes_t strobes,
  output logic         csN,
  output logic         sclk
);
  localparam int PERIOD = 2 * HALF_PERIOD;
  localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int BW     = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [PW-1:0] PHASE_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] SAMPLE_AT  = PW'(SAMPLE_DELAY);
  localparam logic [PW-1:0] HIGH_END   = PW'(HALF_PERIOD);
  localparam logic [BW-1:0] BIT_LAST   = BW'(WORD_BITS - 1);

  readState_t    state, stateN;
  logic [PW-1:0] phase, phaseN;
  logic [BW-1:0] bitIdx, bitIdxN;

  always_comb begin
    stateN  = state;
    phaseN  = phase;
    bitIdxN = bitIdx;
    strobes = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          stateN  = ST_FIRST;
          phaseN  = '0;
          bitIdxN = '0;
        end
      end
      ST_FIRST, ST_CLOCK: begin
        strobes.shiftEn = (phase == SAMPLE_AT);
        if (phase == PHASE_LAST) begin
          phaseN = '0;
          if (bitIdx == BIT_LAST) begin
            stateN          = ST_DONE;
            strobes.loadOut = 1'b1;
          end else begin
            stateN  = ST_CLOCK;
            bitIdxN = bitIdx + 1'b1;
          end
        end else begin
          phaseN = phase + 1'b1;
        end
      end
      ST_DONE: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  // pin drivers are registered from the next-state values so they stay glitch free
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
      csN    <= 1'b1;
      sclk   <= 1'b0;
    end else begin
      state  <= stateN;
      phase  <= phaseN;
      bitIdx <= bitIdxN;
      csN    <= (stateN == ST_IDLE);
      sclk   <= (stateN == ST_CLOCK) && (phaseN < HIGH_END);
    end
  end
endmodule

// File: rtl/sdadc_reader_datapath.sv
module sdadc_reader_datapath
  import sdadc_reader_pkg::*;
#(
  parameter int WORD_BITS = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  input  logic                 sdata,
  output logic [WORD_BITS-1:0] word,
  output logic                 wordValid
);
  logic [WORD_BITS-1:0] shiftReg;

  generate
    if (WORD_BITS > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)                  shiftReg <= '0;
        else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_BITS-2:0], sdata};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)                  shiftReg <= '0;
        else if (strobes.shiftEn) shiftReg <= sdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      word      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobes.loadOut;
      if (strobes.loadOut) word <= shiftReg;
    end
  end
endmodule

// File: rtl/sdadc_reader.sv
module sdadc_reader
  import sdadc_reader_pkg::*;
#(
  parameter int WORD_BITS    = 20,
  parameter int HALF_PERIOD  = 4,
  parameter int SAMPLE_DELAY = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 readyN,
  input  logic                 sdata,
  output logic                 csN,
  output logic                 sclk,
  output logic [WORD_BITS-1:0] word,
  output logic                 wordValid
);
  logic         startPulse;
  ctrlStrobes_t strobes;

  sdadc_reader_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .readyN     (readyN),
    .startPulse (startPulse)
  );

  sdadc_reader_ctrl #(
    .WORD_BITS    (WORD_BITS),
    .HALF_PERIOD  (HALF_PERIOD),
    .SAMPLE_DELAY (SAMPLE_DELAY)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .strobes    (strobes),
    .csN        (csN),
    .sclk       (sclk)
  );

  sdadc_reader_datapath #(
    .WORD_BITS (WORD_BITS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .sdata     (sdata),
    .word      (word),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/sdadc_reader_chk.sv
module sdadc_reader_chk #(
  parameter int WORD_BITS = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 csN,
  input logic                 sclk,
  input logic [WORD_BITS-1:0] word,
  input logic                 wordValid
);
  int   riseCount;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (rst || csN) begin
      riseCount <= 0;
      sclkPrev  <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (sclk && !sclkPrev) riseCount <= riseCount + 1;
    end
  end

  AST_MSB_BEFORE_CLOCK:  assert property (@(posedge clk) disable iff (rst) $fell(csN) |-> !sclk);                        // R3
  AST_PULSE_COUNT:       assert property (@(posedge clk) disable iff (rst) wordValid |-> riseCount == WORD_BITS - 1);     // R4
  AST_VALID_ONE_CYCLE:   assert property (@(posedge clk) disable iff (rst) wordValid |=> !wordValid);                     // R7
  AST_VALID_WITH_SELECT: assert property (@(posedge clk) disable iff (rst) wordValid |-> !csN);                            // R7
  AST_WORD_HELD:         assert property (@(posedge clk) disable iff (rst) !$stable(word) |-> wordValid);                 // R7
  AST_RELEASE_AFTER:     assert property (@(posedge clk) disable iff (rst) wordValid |=> csN);                            // R8
  AST_CLOCK_IN_SELECT:   assert property (@(posedge clk) disable iff (rst) sclk |-> !csN);                                // R8
endmodule

bind sdadc_reader sdadc_reader_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .csN       (csN),
  .sclk      (sclk),
  .word      (word),
  .wordValid (wordValid)
);

// File: tb/sdadc_reader_tb.sv
module sdadc_reader_tb;
  localparam int W      = 20;
  localparam int H      = 4;
  localparam int SD     = 4;
  localparam int PER    = 2 * H;
  localparam int DONE_K = W * PER;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         readyN = 1'b1;
  logic         sdata = 1'b0;
  logic         csN, sclk, wordValid;
  logic [W-1:0] word;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] adcWord = '0;

  always #2 clk = ~clk;  // 250 MHz

  sdadc_reader #(.WORD_BITS(W), .HALF_PERIOD(H), .SAMPLE_DELAY(SD)) u_dut (
    .clk(clk), .rst(rst), .readyN(readyN), .sdata(sdata),
    .csN(csN), .sclk(sclk), .word(word), .wordValid(wordValid)
  );

  // converter model: MSB on select fall, next bit on every rising serial clock
  int adcIdx = 0;
  always @(negedge csN) begin
    adcIdx = 0;
    sdata  = adcWord[W-1];
  end
  always @(posedge sclk) begin
    adcIdx++;
    if (adcIdx < W) sdata = adcWord[W-1-adcIdx];
  end

  // behavioural reference: history of sampled ready values and an elapsed counter
  bit           hist[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
  bit           busy = 1'b0;
  int           k = 0;
  logic [W-1:0] expWord = '0;
  int           starts = 0;

  always @(posedge clk) begin
    hist.push_back(rst ? 1'b1 : readyN);
    void'(hist.pop_front());
    if (rst) begin
      busy = 1'b0; k = 0; expWord = '0;
    end else if (busy) begin
      k++;
      if (k == DONE_K) expWord = adcWord;
      if (k > DONE_K) busy = 1'b0;
    end else if (hist[0] == 1'b1 && hist[1] == 1'b0) begin
      busy = 1'b1; k = 0; starts++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic expCs, expSclk, expValid;
    if (!rst) begin
      expCs    = !busy;
      expSclk  = busy && k < DONE_K && k >= PER && (k % PER) < H;
      expValid = busy && k == DONE_K;
      check(csN == expCs, "R2/R8 csN", W'(csN), W'(expCs));
      check(sclk == expSclk, "R3/R4 sclk", W'(sclk), W'(expSclk));
      check(wordValid == expValid, "R7 wordValid", W'(wordValid), W'(expValid));
      check(word == expWord, "R5/R6/R7 word", word, expWord);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readOnce(input logic [W-1:0] value);
    adcWord = value;
    readyN  = 1'b0;
    while (!wordValid) @(negedge clk);
    check(word == value, "R6 assembled word", word, value);
    readyN = 1'b1;
    cycles(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    cycles(3);
    check(csN == 1'b1 && sclk == 1'b0 && wordValid == 1'b0, "R1 reset pins", {csN, sclk, wordValid}, 3'b100);
    check(word == '0, "R1 reset word", word, '0);
    rst = 1'b0;
    cycles(4);

    readOnce(20'hABCDE);
    readOnce(20'h00000);
    readOnce(20'hFFFFF);
    readOnce(20'h80001);
    readOnce(20'h5A5A5);

    // R9: ready rises and falls again mid-read; read completes once
    s0 = starts;
    adcWord = 20'h3C0F1;
    readyN  = 1'b0;
    cycles(30);
    readyN = 1'b1;
    cycles(20);
    readyN = 1'b0;
    cycles(10);
    readyN = 1'b1;
    while (!wordValid) @(negedge clk);
    check(word == 20'h3C0F1, "R9 word after ready toggles", word, 20'h3C0F1);
    cycles(10);
    check(starts == s0 + 1, "R9 single start", W'(starts - s0), W'(1));

    // R10: ready held low after a read does not retrigger
    s0 = starts;
    adcWord = 20'h12345;
    readyN  = 1'b0;
    while (!wordValid) @(negedge clk);
    cycles(300);
    check(csN == 1'b1, "R10 no retrigger csN", W'(csN), W'(1));
    check(starts == s0 + 1, "R10 single start", W'(starts - s0), W'(1));
    readyN = 1'b1;
    cycles(6);

    // ready pulse swept across the end of a read (R9 boundary vs next start)
    for (int d = DONE_K - 6; d <= DONE_K + 4; d++) begin
      adcWord = W'(32'h9E3 * (d + 7));
      readyN  = 1'b0;
      while (csN) @(negedge clk);
      readyN = 1'b1;
      cycles(d);
      readyN = 1'b0;
      cycles(1);
      readyN = 1'b1;
      cycles(2 * DONE_K);
    end

    // reset in the middle of a read, then a clean read (R1)
    adcWord = 20'hC3A5F;
    readyN  = 1'b0;
    cycles(70);
    rst = 1'b1;
    cycles(2);
    check(csN == 1'b1 && sclk == 1'b0 && word == '0, "R1 mid-read reset", word, '0);
    rst    = 1'b0;
    readyN = 1'b1;
    cycles(5);
    readOnce(20'h0F0F0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule